// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small processor built around one 16-bit accumulator. Instructions and data share the same 16-bit word and the same memory. The core repeats a fixed sequence. First it fetches the word that the program counter points to. Then it executes that word as one of three direct-address operations: copy a memory word into the accumulator, write the accumulator out to memory, or add a memory word to the accumulator.

The core drives one synchronous, word-addressed memory. It presents an address and a read strobe, and it takes the returned word one cycle later. To write, it presents an address, a data word and a write strobe. All traffic passes through an internal address register and an internal data buffer register. When the core meets a word whose opcode it does not know, it stops and raises a halt flag, which stays up until the next reset.

Top module: `acc_core`

## Requirements
- R1: An instruction word carries its opcode in bits [15:12] and its operand address in bits [11:0]. Each fetch issues a read at the current program counter value, and the returned word becomes the instruction register.
- R2: While `rst_n` is low, the program counter, accumulator and instruction register hold zero, `halted` is low and neither strobe is raised. The first read after reset is at address 0. A store executed before any load writes 0.
- R3: Opcode 1 places the memory word at the operand address into the accumulator.
- R4: Opcode 2 raises `mem_wr` for exactly one cycle, with `mem_addr` equal to the operand address and `mem_wdata` equal to the accumulator.
- R5: Opcode 5 adds the memory word at the operand address to the accumulator. The sum wraps modulo 2^16.
- R6: The program counter advances by one during the fetch, before the fetched word executes. Instructions run in address order, so a store that overwrites the next program word changes what is fetched next.
- R7: Any opcode other than 1, 2 or 5 drives `halted` high. It then stays high with no memory strobe until reset, and the memory is left untouched.
- R8: Read data is taken one cycle after `mem_rd`, and `mem_rd` and `mem_wr` are never high together. Load and add take 7 cycles, a store takes 5, and an unknown opcode reaches the halt state 4 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rd | output | 1 | Read strobe; data expected on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once an unknown opcode has been decoded |

## Verification
Two functions can act on the same word within one instruction. The first is the program counter step taken during fetch. The second is a store that writes the very next program location. The bench provokes this with a program that loads an encoded store instruction and writes it over the halt word that follows. The bench judges the outcome by whether the overwritten word is then fetched and executed: a second location must receive the accumulator, and the cycle count to halt must match the count for an extra store. Wrapping addition is swept over a grid of operand pairs that includes the carry-out corners.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int ADDR_W = WORD_W - OP_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'd5;

    typedef enum logic [2:0] {
        ST_FADDR  = 3'd0,
        ST_FREAD  = 3'd1,
        ST_FCAPT  = 3'd2,
        ST_DECODE = 3'd3,
        ST_EMEM   = 3'd4,
        ST_ECAPT  = 3'd5,
        ST_EDO    = 3'd6,
        ST_HALT   = 3'd7
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   mar;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   acc;
        logic [WORD_W-1:0]   mbr;
    } core_regs_t;

    localparam core_regs_t CORE_RESET = '{
        st:  ST_FADDR,
        pc:  '0,
        mar: '0,
        ir:  '0,
        acc: '0,
        mbr: '0
    };
endpackage

// File: rtl/acc_decode.sv
module acc_decode #(
    parameter int OP_W = 4,
    parameter logic [OP_W-1:0] LOAD_CODE  = 1,
    parameter logic [OP_W-1:0] STORE_CODE = 2,
    parameter logic [OP_W-1:0] ADD_CODE   = 5
) (
    input  logic [OP_W-1:0] opcode,
    output logic            is_load,
    output logic            is_store,
    output logic            is_add,
    output logic            is_bad
);
    always_comb begin
        is_load  = (opcode == LOAD_CODE);
        is_store = (opcode == STORE_CODE);
        is_add   = (opcode == ADD_CODE);
        is_bad   = !(is_load || is_store || is_add);
    end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // carry out of the top bit is dropped: modulo 2^W
    always_comb sum = a + b;
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    core_regs_t r_q, r_d;

    logic [OP_W-1:0]   op_field;
    logic [ADDR_W-1:0] addr_field;
    logic              dec_load, dec_store, dec_add, dec_bad;
    logic [WORD_W-1:0] acc_sum;
    logic [ADDR_W-1:0] pc_next;

    assign op_field   = r_q.ir[WORD_W-1 -: OP_W];
    assign addr_field = r_q.ir[ADDR_W-1:0];

    acc_decode #(
        .OP_W       (OP_W),
        .LOAD_CODE  (OPC_LOAD),
        .STORE_CODE (OPC_STORE),
        .ADD_CODE   (OPC_ADD)
    ) u_dec (
        .opcode   (op_field),
        .is_load  (dec_load),
        .is_store (dec_store),
        .is_add   (dec_add),
        .is_bad   (dec_bad)
    );

    acc_adder #(.W(WORD_W)) u_acc_add (
        .a   (r_q.acc),
        .b   (r_q.mbr),
        .sum (acc_sum)
    );

    acc_adder #(.W(ADDR_W)) u_pc_inc (
        .a   (r_q.pc),
        .b   (ADDR_W'(1)),
        .sum (pc_next)
    );

    always_comb begin
        r_d       = r_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = r_q.mar;
        mem_wdata = r_q.mbr;
        case (r_q.st)
            ST_FADDR: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_FREAD;
            end
            ST_FREAD: begin
                mem_rd = 1'b1;
                r_d.st = ST_FCAPT;
            end
            ST_FCAPT: begin
                r_d.mbr = mem_rdata;
                r_d.ir  = mem_rdata;
                r_d.pc  = pc_next;
                r_d.st  = ST_DECODE;
            end
            ST_DECODE: begin
                if (dec_bad) begin
                    r_d.st = ST_HALT;
                end else begin
                    r_d.mar = addr_field;
                    if (dec_store) r_d.mbr = r_q.acc;
                    r_d.st = ST_EMEM;
                end
            end
            ST_EMEM: begin
                if (dec_store) begin
                    mem_wr = 1'b1;
                    r_d.st = ST_FADDR;
                end else begin
                    mem_rd = 1'b1;
                    r_d.st = ST_ECAPT;
                end
            end
            ST_ECAPT: begin
                r_d.mbr = mem_rdata;
                r_d.st  = ST_EDO;
            end
            ST_EDO: begin
                if (dec_load)     r_d.acc = r_q.mbr;
                else if (dec_add) r_d.acc = acc_sum;
                r_d.st = ST_FADDR;
            end
            ST_HALT: begin
                r_d.st = ST_HALT;
            end
            default: begin
                r_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CORE_RESET;
        else        r_q <= r_d;
    end

    assign halted = (r_q.st == ST_HALT);
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              halted,
    input state_e            st,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ir,
    input logic [WORD_W-1:0] acc,
    input logic [WORD_W-1:0] mbr
);
    assert_rw_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREAD) |-> (mem_addr == pc));

    assert_ir_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCAPT) |=> (ir == $past(mem_rdata)));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCAPT) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_store_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc && mem_addr == ir[ADDR_W-1:0]
                    && ir[WORD_W-1 -: OP_W] == OPC_STORE));

    assert_load_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EDO && ir[WORD_W-1 -: OP_W] == OPC_LOAD) |=> (acc == $past(mbr)));

    assert_add_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EDO && ir[WORD_W-1 -: OP_W] == OPC_ADD)
            |=> (acc == WORD_W'($past(acc) + $past(mbr))));
endmodule

bind acc_core acc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .st        (r_q.st),
    .pc        (r_q.pc),
    .ir        (r_q.ir),
    .acc       (r_q.acc),
    .mbr       (r_q.mbr)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata = '0;
    logic        halted;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [256];
    int          halt_access = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // synchronous memory model, one cycle read latency
    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= mem[mem_addr[7:0]];
        if (halted && (mem_rd || mem_wr)) halt_access <= halt_access + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        ld_addr = a;
        ld_data = d;
        ld_en   = 1'b1;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        rst_n = 1'b1;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [15:0] instr(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] vals [8];
        int cyc;
        int snap;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hFFFE; vals[7] = 16'hA5A5;

        @(negedge clk);
        for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);

        // R2: reset state at the ports
        chk(halted == 1'b0, "R2 halted in reset", 32'(halted), 0);
        chk(!mem_rd && !mem_wr, "R2 strobes in reset", {mem_rd, mem_wr}, 0);

        // R2/R1: first fetch at address 0; store before load writes zero
        poke(8'h00, instr(4'd2, 12'h080));
        poke(8'h01, 16'h0000);
        poke(8'h80, 16'hBEEF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_rd && mem_addr == 12'h000, "R1 first fetch addr", 32'(mem_addr), 0);
        run(cyc);
        chk(mem[8'h80] == 16'h0000, "R2 accumulator cleared", 32'(mem[8'h80]), 0);
        chk(cyc == 8, "R8 store+halt cycles", cyc, 8);
        hold_reset();

        // R3: load then store, cycle count
        poke(8'h00, instr(4'd1, 12'h010));
        poke(8'h01, instr(4'd2, 12'h012));
        poke(8'h02, 16'h0000);
        poke(8'h10, 16'h5A3C);
        poke(8'h12, 16'hDEAD);
        run(cyc);
        chk(mem[8'h12] == 16'h5A3C, "R3 load value", 32'(mem[8'h12]), 32'h5A3C);
        chk(cyc == 16, "R8 load+store+halt cycles", cyc, 16);
        hold_reset();

        // R5/R4: sweep addition over operand grid
        poke(8'h00, instr(4'd1, 12'h010));
        poke(8'h01, instr(4'd5, 12'h011));
        poke(8'h02, instr(4'd2, 12'h012));
        poke(8'h03, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] exp_sum;
                exp_sum = 16'((32'(vals[i]) + 32'(vals[j])) % 32'h10000);
                poke(8'h10, vals[i]);
                poke(8'h11, vals[j]);
                poke(8'h12, 16'hDEAD);
                run(cyc);
                chk(mem[8'h12] == exp_sum, "R5 wrapped sum", 32'(mem[8'h12]), 32'(exp_sum));
                chk(mem[8'h10] == vals[i] && mem[8'h11] == vals[j], "R4 operands kept",
                    {mem[8'h10], mem[8'h11]}, {vals[i], vals[j]});
                if (i == 0 && j == 0) chk(cyc == 23, "R8 load+add+store+halt cycles", cyc, 23);
                hold_reset();
            end
        end

        // R6: sequential accumulation chain
        poke(8'h00, instr(4'd1, 12'h050));
        poke(8'h01, instr(4'd5, 12'h051));
        poke(8'h02, instr(4'd5, 12'h052));
        poke(8'h03, instr(4'd5, 12'h053));
        poke(8'h04, instr(4'd2, 12'h060));
        poke(8'h05, 16'h0000);
        poke(8'h50, 16'h1000); poke(8'h51, 16'h0200);
        poke(8'h52, 16'h0030); poke(8'h53, 16'hF004);
        run(cyc);
        chk(mem[8'h60] == 16'h0234, "R6 chain sum", 32'(mem[8'h60]), 32'h0234);
        chk(cyc == 7 * 4 + 5 + 4, "R6 chain cycles", cyc, 7 * 4 + 5 + 4);
        hold_reset();

        // R6: store overwrites the next program word, which is then fetched
        for (int i = 0; i < 8; i++) poke(8'(i), 16'h0000);
        poke(8'h00, instr(4'd1, 12'h030));
        poke(8'h01, instr(4'd2, 12'h002));
        poke(8'h30, instr(4'd2, 12'h040));
        poke(8'h40, 16'h0000);
        run(cyc);
        chk(mem[8'h02] == 16'h2040, "R6 program word rewritten", 32'(mem[8'h02]), 32'h2040);
        chk(mem[8'h40] == 16'h2040, "R6 rewritten word executed", 32'(mem[8'h40]), 32'h2040);
        chk(cyc == 21, "R6 rewritten program cycles", cyc, 21);
        hold_reset();

        // R7: every unknown opcode halts, stays halted, leaves memory alone
        for (int op = 0; op < 16; op++) begin
            if (op != 1 && op != 2 && op != 5) begin
                poke(8'h00, instr(4'(op), 12'h020));
                poke(8'h20, 16'h1111);
                run(cyc);
                chk(halted && cyc == 4, "R7 halt reached", cyc, 4);
                snap = halt_access;
                repeat (20) @(negedge clk);
                chk(halted == 1'b1, "R7 halt sticky", 32'(halted), 1);
                chk(halt_access == snap, "R7 no access while halted", halt_access, snap);
                chk(mem[8'h20] == 16'h1111, "R7 memory untouched", 32'(mem[8'h20]), 32'h1111);
                hold_reset();
                chk(halted == 1'b0, "R7 reset clears halt", 32'(halted), 0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule